// File: doc/BRIEF.md
# Flash Configuration Word Command Sequencer

This block models the command side of a synchronous flash device's bus interface: the part that lets a host change how the read path behaves. The host loads a 16-bit configuration word with two back-to-back write cycles on the bus. The first is a setup write and the second is a confirm write. In both cycles the configuration value travels on the low sixteen address lines. The command opcode travels on the data bus. The block keeps the accepted word and presents it to the read logic. Once the confirm write ends, the block falls back to read-array mode without further action from the host.

A write cycle is open while chip enable and write enable are both low. Address and data are taken from the first clock sample where any of the three active-low strobes (chip enable, write enable or address valid) has risen. Rises of the other strobes in that same cycle are ignored. The host can read the stored word back. To do so it writes the identify command and then reads a fixed offset, which is 0x05 by default. The programming supply level plays no part in the sequence, and the block has no input for it.

All strobes are sampled on the system clock. A reset synchroniser drives the internal reset: it asserts at once and releases two clocks after `rst_n` rises.

Top module: `flash_cfg_sequencer`

## Requirements
- R1: After reset, `cfg_word` is 0xBFC7, `id_mode` is 0 and `rd_data` is 0 at every address. In 0xBFC7, bit 15 = 1, bits [13:11] = 111, bits [10:6] are all 1, bits [3:0] = 0111, and bits 14, 5 and 4 are 0.
- R2: A write with data 0x0060 followed by a write with data 0x0003 sets `cfg_word` to the confirm cycle's `addr[15:0]`, with the reserved bits forced to 0. The data bus never supplies configuration bits. An opcode must have every data bit above bit 7 at zero.
- R3: A setup write on its own leaves `cfg_word` unchanged.
- R4: If the write after a setup carries any opcode other than 0x0003, `cfg_word` is left unchanged and the block returns to read-array mode (`id_mode` = 0). This holds even when the block was in identifier mode before the setup.
- R5: Address and data are captured on the clock sample that first shows a rising edge of `ce_n`, `we_n` or `adv_n` while `ce_n` and `we_n` were low. Bus changes after that sample, within the same cycle, have no effect. This works whichever strobe rises first.
- R6: Bits 14, 5 and 4 of `cfg_word` always read 0, whatever value is written to them.
- R7: After an accepted confirm write the block is in read-array mode, even if it was in identifier mode before the setup.
- R8: Opcode 0x0090 puts the block in identifier mode (`id_mode` = 1). In that mode `rd_data` equals `cfg_word` when `addr` = 0x05 and is 0 at every other address. In read-array mode `rd_data` is 0.
- R9: Opcode 0x00FF returns the block from identifier mode to read-array mode. Other opcodes given outside a setup/confirm pair leave the mode unchanged.
- R10: One write cycle yields exactly one capture, however many strobes rise during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| addr | input | ADDR_W | Address bus; bits [15:0] carry the configuration value |
| data_in | input | DATA_W | Data bus; carries the command opcode |
| cfg_word | output | 16 | Active configuration word |
| id_mode | output | 1 | 1 = identifier mode, 0 = read-array mode |
| rd_data | output | DATA_W | Read value: the configuration word at the identifier offset in identifier mode, otherwise 0 |

## Verification
Two things can land in the same clock: the capture triggered by one strobe, and the rise of a second strobe that belongs to the same write cycle. The bench provokes this by raising `adv_n` on its own first, then changing the bus to non-opcode values, then raising `ce_n` and `we_n` together. It also raises all three strobes together. The result is judged by the committed word and the mode. If the second rise were taken as a new capture, it would abandon the setup, and the confirm that follows would then find the block in read-array mode and not commit.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;
  localparam int CFG_W  = 16;
  localparam int NSTB   = 3;
  localparam int IDX_CE  = 0;
  localparam int IDX_WE  = 1;
  localparam int IDX_ADV = 2;

  localparam logic [7:0] OP_SETUP   = 8'h60;
  localparam logic [7:0] OP_CONFIRM = 8'h03;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

  localparam logic [CFG_W-1:0] CFG_RESET = 16'hBFC7;
  localparam logic [CFG_W-1:0] CFG_WMASK = 16'hBFCF;

  typedef enum logic [1:0] {
    ST_ARRAY = 2'd0,
    ST_SETUP = 2'd1,
    ST_IDENT = 2'd2
  } cmd_state_e;
endpackage

// File: rtl/fcs_strobe_capture.sv
module fcs_strobe_capture
  import flash_cfg_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTB-1:0]   stb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  logic [NSTB-1:0] prev_q;
  logic [NSTB-1:0] rise;
  logic            cycle_live;
  logic            cap_event;
  logic            done_q, done_d;

  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= stb_n[i];
    end
    assign rise[i] = stb_n[i] & ~prev_q[i];
  end

  always_comb begin
    cycle_live = ~prev_q[IDX_CE] & ~prev_q[IDX_WE];
    cap_event  = cycle_live & ~done_q & (|rise);
    done_d     = cap_event | (done_q & ~stb_n[IDX_CE] & ~stb_n[IDX_WE]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      done_q    <= done_d;
      cap_valid <= cap_event;
      if (cap_event) begin
        cap_addr <= addr;
        cap_data <= data;
      end
    end
  end

  // R10: one capture per write cycle
  p_one_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> !cap_event);
endmodule

// File: rtl/fcs_cmd_fsm.sv
module fcs_cmd_fsm
  import flash_cfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  output logic              commit,
  output logic              pending,
  output logic              id_mode
);
  cmd_state_e state_q, state_d;
  logic is_setup, is_confirm, is_ident, is_array;

  always_comb begin
    is_setup   = (cap_data == DATA_W'(OP_SETUP));
    is_confirm = (cap_data == DATA_W'(OP_CONFIRM));
    is_ident   = (cap_data == DATA_W'(OP_IDENT));
    is_array   = (cap_data == DATA_W'(OP_ARRAY));
    state_d    = state_q;
    commit     = 1'b0;
    if (cap_valid) begin
      case (state_q)
        ST_SETUP: begin
          commit  = is_confirm;
          state_d = ST_ARRAY;
        end
        default: begin
          if (is_setup)      state_d = ST_SETUP;
          else if (is_ident) state_d = ST_IDENT;
          else if (is_array) state_d = ST_ARRAY;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARRAY;
    else        state_q <= state_d;
  end

  assign pending = (state_q == ST_SETUP);
  assign id_mode = (state_q == ST_IDENT);

  // R7 / R4: any write after setup lands in read-array mode
  p_confirm_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && cap_valid) |=> (state_q == ST_ARRAY));
  // R2: setup state is only entered through a captured write
  p_setup_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && $past(state_q) != ST_SETUP) |-> $past(cap_valid));
endmodule

// File: rtl/fcs_cfg_store.sv
module fcs_cfg_store
  import flash_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (commit) cfg_d = wdata & CFG_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  // R3: without a commit the word holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_q));
endmodule

// File: rtl/flash_cfg_sequencer.sv
module flash_cfg_sequencer
  import flash_cfg_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int ID_OFS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [CFG_W-1:0]  cfg_word,
  output logic              id_mode,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [NSTB-1:0]   stb_n;
  logic              cap_valid;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              commit;
  logic              pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_comb begin
    stb_n          = '1;
    stb_n[IDX_CE]  = ce_n;
    stb_n[IDX_WE]  = we_n;
    stb_n[IDX_ADV] = adv_n;
  end

  fcs_strobe_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_s_n), .stb_n(stb_n), .addr(addr), .data(data_in),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  fcs_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .cap_valid(cap_valid), .cap_data(cap_data),
    .commit(commit), .pending(pending), .id_mode(id_mode)
  );

  fcs_cfg_store u_store (
    .clk(clk), .rst_n(rst_s_n), .commit(commit),
    .wdata(cap_addr[CFG_W-1:0]), .cfg_q(cfg_word)
  );

  always_comb begin
    rd_data = '0;
    if (id_mode && addr == ADDR_W'(ID_OFS)) rd_data = DATA_W'(cfg_word);
  end

  // R6: reserved bits stay clear
  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_word & ~CFG_WMASK) == '0);
  // R4: the word can only change right after a pending setup
  p_change_needs_setup_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(cfg_word) |-> $past(pending));
  // R8: array mode never returns the word
  p_array_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !id_mode |-> (rd_data == '0));
endmodule

// File: tb/flash_cfg_sequencer_test.sv
module flash_cfg_sequencer_test;
  localparam int AW = 23;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, we_n, adv_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data_in;
  logic [15:0]   cfg_word;
  logic          id_mode;
  logic [DW-1:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flash_cfg_sequencer #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .adv_n(adv_n),
    .addr(addr), .data_in(data_in), .cfg_word(cfg_word),
    .id_mode(id_mode), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // first: bit0 ce, bit1 we, bit2 adv rise first; the rest rise later
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [2:0] first);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; adv_n = 1'b0; addr = a; data_in = d;
    @(negedge clk);
    if (first[0]) ce_n  = 1'b1;
    if (first[1]) we_n  = 1'b1;
    if (first[2]) adv_n = 1'b1;
    @(negedge clk);
    addr = ~a; data_in = ~d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; adv_n = 1'b1;
    @(negedge clk);
    addr = '0; data_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic load(input logic [15:0] v, input logic [2:0] first);
    bus_write(AW'(v), 16'h0060, first);
    bus_write(AW'(v), 16'h0003, first);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    chk("R1 cfg", 32'(cfg_word), 32'hBFC7);
    chk("R1 id_mode", 32'(id_mode), 32'h0);
    peek(AW'(5), v);
    chk("R1 rd_data", 32'(v), 32'h0);
  endtask

  task automatic t_load;
    load(16'h0A83, 3'b111);
    chk("R2 load", 32'(cfg_word), 32'h0A83);
    chk("R2 mode", 32'(id_mode), 32'h0);
  endtask

  task automatic t_setup_abort;
    bus_write(AW'(16'h5555), 16'h0060, 3'b111);
    chk("R3 setup only", 32'(cfg_word), 32'h0A83);
    bus_write(AW'(16'h5555), 16'h00FF, 3'b111);
    chk("R4 abort cfg", 32'(cfg_word), 32'h0A83);
    bus_write(AW'(0), 16'h0090, 3'b111);
    bus_write(AW'(16'h1111), 16'h0060, 3'b111);
    bus_write(AW'(16'h1111), 16'h0002, 3'b111);
    chk("R4 abort from id cfg", 32'(cfg_word), 32'h0A83);
    chk("R4 abort from id mode", 32'(id_mode), 32'h0);
  endtask

  task automatic t_first_strobe;
    load(16'h0001, 3'b001);
    chk("R5 ce first", 32'(cfg_word), 32'h0001);
    load(16'h0002, 3'b010);
    chk("R5 we first", 32'(cfg_word), 32'h0002);
    load(16'h0083, 3'b100);
    chk("R5 adv first", 32'(cfg_word), 32'h0083);
  endtask

  task automatic t_reserved;
    load(16'hFFFF, 3'b111);
    chk("R6 reserved", 32'(cfg_word), 32'hBFCF);
  endtask

  task automatic t_ident;
    logic [DW-1:0] v;
    bus_write(AW'(0), 16'h0090, 3'b111);
    chk("R8 id mode", 32'(id_mode), 32'h1);
    peek(AW'(5), v);
    chk("R8 read ofs 5", 32'(v), 32'hBFCF);
    peek(AW'(6), v);
    chk("R8 read ofs 6", 32'(v), 32'h0);
    bus_write(AW'(0), 16'h0042, 3'b111);
    chk("R9 unknown op keeps mode", 32'(id_mode), 32'h1);
    bus_write(AW'(0), 16'h00FF, 3'b111);
    chk("R9 back to array", 32'(id_mode), 32'h0);
    peek(AW'(5), v);
    chk("R8 array read", 32'(v), 32'h0);
  endtask

  task automatic t_id_then_cfg;
    bus_write(AW'(0), 16'h0090, 3'b111);
    load(16'h1C47, 3'b111);
    chk("R7 cfg", 32'(cfg_word), 32'h1C47);
    chk("R7 mode", 32'(id_mode), 32'h0);
  endtask

  task automatic t_double_rise;
    bus_write(AW'(16'h0123), 16'h0060, 3'b100);
    bus_write(AW'(16'h0123), 16'h0003, 3'b100);
    chk("R10 single capture", 32'(cfg_word), 32'h0103);
    load(16'h0A81, 3'b111);
    chk("R10 simultaneous", 32'(cfg_word), 32'h0A81);
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; adv_n = 1'b1;
    addr = '0; data_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_load();
    t_setup_abort();
    t_first_strobe();
    t_reserved();
    t_ident();
    t_id_then_cfg();
    t_double_rise();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule